// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Single-Pass Rounding

This block multiplies two single-precision binary floating-point operands and returns the product rounded to nearest, ties to even. The 24x24 significand product is kept in carry-save form, as one sum vector and one carry vector. A single carry-propagate stage then settles the final addition, the one-bit normalization and the rounding together. It does so by producing three candidates for the upper field of the product (the raw sum, sum plus one and sum plus two) and letting a small decoder pick one of them. No second rounding adder follows normalization.

Exponents are added and the bias is removed. The sign is the XOR of the operand signs. Zero, infinity and NaN operands are handled. Denormal operands count as zero, and any result too small to be normal becomes a signed zero. The datapath is combinational from operands to the result register, so a product appears one clock after its operands are sampled.

Top module: `fmul_rne`

## Requirements
- R1: `prod_o` is cleared to 0x00000000 while `rst_ni` is low, and the reset takes effect without waiting for a clock edge. After reset, the product of the operands sampled at a rising edge of `clk_i` appears on `prod_o` right after that edge and holds until the next edge.
- R2: For normal operands whose result is normal, `prod_o` is the exact product rounded to nearest, with a tie rounded toward the even significand. Fields: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0.
- R3: The rounded significand is taken from exactly one of three upper-field candidates (sum, sum+1, sum+2), chosen by a select code of 0, 1 or 2; the code 3 never occurs. When the significand product is 2 or more, the chosen value is shifted right by one and the exponent grows by one. A rounding carry that brings the significand to 2.0 also raises the exponent.
- R4: The result exponent is the sum of the biased exponents minus 127, plus the normalization increments. If that value is 255 or more, the output is a signed infinity (exponent 0xFF, fraction 0).
- R5: If the result exponent after rounding is 0 or less, the output is a zero that keeps the product sign.
- R6: An operand whose exponent field is 0 (zero or denormal) is taken as zero. A finite product with such an operand is a signed zero.
- R7: If either operand is a NaN (exponent 0xFF, fraction non-zero), or one operand is infinite and the other is taken as zero, the output is 0x7FC00000.
- R8: An infinite operand times a non-zero non-NaN operand gives an infinity with the product sign.
- R9: Unless the output is NaN, its sign bit is the XOR of the operand sign bits.
- R10: The carry-save sum and carry vectors add, modulo 2^48, to the product of the two 24-bit significands (hidden one included).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_i | input | 32 | First operand, single-precision encoding |
| op_b_i | input | 32 | Second operand, single-precision encoding |
| prod_o | output | 32 | Registered rounded product |

## Verification
The clocked properties assume that both operands are stable around each rising clock edge. The stimulus meets this by changing operands only on falling edges. They also assume that any 32-bit pattern may appear, so the special-value and range checks must hold for every input. For that reason the stimulus mixes unconstrained random words, which reach NaN, infinity, denormal and out-of-range exponents, with words whose exponents sit in a middle band, which exercise the rounding decoder on normal results. Directed vectors add exact ties, a rounding carry up to 2.0 and both exponent boundaries.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int PROD_W = 2 * MANT_W;
  localparam int LO_W   = FRAC_W;            // bits below the unnormalized LSB
  localparam int UP_W   = PROD_W - LO_W;     // upper field carrying the significand
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int ECALC_W = EXP_W + 3;
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;
endpackage

// File: rtl/fmul_csa.sv
module fmul_csa #(
  parameter int MW = 24,
  localparam int PW = 2 * MW
) (
  input  logic [MW-1:0] ma_i,
  input  logic [MW-1:0] mb_i,
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] cry_o
);
  for (genvar j = 0; j < MW; j++) begin : g_row
    logic [PW-1:0] pp, s, c;
    assign pp = mb_i[j] ? ({{MW{1'b0}}, ma_i} << j) : '0;
    if (j == 0) begin : g_first
      assign s = pp;
      assign c = '0;
    end else begin : g_next
      logic [PW-1:0] ps, pc;
      assign ps = g_row[j-1].s;
      assign pc = g_row[j-1].c;
      assign s  = ps ^ pc ^ pp;
      assign c  = ((ps & pc) | (ps & pp) | (pc & pp)) << 1;
    end
  end

  assign sum_o = g_row[MW-1].s;
  assign cry_o = g_row[MW-1].c;
endmodule

// File: rtl/fmul_ks.sv
module fmul_ks #(
  parameter int N = 23,
  localparam int LV = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] p_o
);
  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    localparam logic [N-1:0] LOWMASK = N'((1 << D) - 1);
    logic [N-1:0] gi, pi, go, po;
    if (lv == 0) begin : g_src
      assign gi = g_i;
      assign pi = p_i;
    end else begin : g_src
      assign gi = g_lvl[lv-1].go;
      assign pi = g_lvl[lv-1].po;
    end
    assign go = gi | (pi & (gi << D));
    assign po = pi & ((pi << D) | LOWMASK);
  end

  assign g_o = g_lvl[LV-1].go;
  assign p_o = g_lvl[LV-1].po;
endmodule

// File: rtl/fmul_flag_add.sv
module fmul_flag_add #(
  parameter int W = 25,
  localparam int N = W - 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum0_o,
  output logic [W-1:0] sum1_o,
  output logic [W-1:0] sum2_o
);
  logic [W-1:0] hs, hc, p;
  logic [N-1:0] gb, gp, pp;
  logic [W-2:0] c0, c1, c2;

  // half-adder row: carry LSB is zero, so +2 enters at bit 1
  assign hs = a_i ^ b_i;
  assign hc = {a_i[W-2:0] & b_i[W-2:0], 1'b0};
  assign p  = hs ^ hc;
  assign gb = hs[W-2:1] & hc[W-2:1];

  fmul_ks #(.N(N)) u_ks (
    .g_i(gb),
    .p_i(p[W-2:1]),
    .g_o(gp),
    .p_o(pp)
  );

  // carries into bits W-1..1 for each increment
  assign c0 = {gp, 1'b0};
  assign c1 = {gp | (pp & {N{p[0]}}), p[0]};
  assign c2 = {gp | pp, 1'b1};

  assign sum0_o = {p[W-1:1] ^ c0, p[0]};
  assign sum1_o = {p[W-1:1] ^ c1, ~p[0]};
  assign sum2_o = {p[W-1:1] ^ c2, p[0]};
endmodule

// File: rtl/fmul_rnd_sel.sv
module fmul_rnd_sel (
  input  logic       lo_cy_i,
  input  logic       lo_top_i,
  input  logic       sticky_i,
  input  logic       msb_i,
  input  logic [1:0] up_lo_i,
  output logic [1:0] sel_o
);
  logic rnd_up;

  always_comb begin
    if (!msb_i) begin
      // LSB at up_lo[0], guard = lo_top
      rnd_up = lo_top_i & (sticky_i | up_lo_i[0]);
      sel_o  = 2'({1'b0, lo_cy_i}) + 2'({1'b0, rnd_up});
    end else begin
      // LSB at up_lo[1], guard = up_lo[0]; odd-sum +3 collapses onto +2
      rnd_up = up_lo_i[0] & (lo_top_i | sticky_i | up_lo_i[1]);
      sel_o  = rnd_up ? 2'd2 : {1'b0, lo_cy_i};
    end
  end
endmodule

// File: rtl/fmul_rne.sv
module fmul_rne
  import fmul_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic [WORD_W-1:0] prod_o
);
  fp_word_t a, b;
  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  logic nan_c, inf_c, zero_c, sgn;
  logic [MANT_W-1:0] ma, mb;
  logic [PROD_W-1:0] s_vec, c_vec;
  logic [LO_W-1:0]   lo_sum;
  logic              lo_cy;
  logic [UP_W-1:0]   cand0, cand1, cand2, res;
  logic [1:0]        sel;
  logic              msb, ovf;
  logic [FRAC_W-1:0] frac;
  logic signed [ECALC_W-1:0] e_calc;
  logic [WORD_W-1:0] prod_d;

  assign a = fp_word_t'(op_a_i);
  assign b = fp_word_t'(op_b_i);

  assign a_zero = (a.expo == '0);
  assign b_zero = (b.expo == '0);
  assign a_inf  = (a.expo == EXP_W'(EXP_MAX)) && (a.frac == '0);
  assign b_inf  = (b.expo == EXP_W'(EXP_MAX)) && (b.frac == '0);
  assign a_nan  = (a.expo == EXP_W'(EXP_MAX)) && (a.frac != '0);
  assign b_nan  = (b.expo == EXP_W'(EXP_MAX)) && (b.frac != '0);
  assign nan_c  = a_nan | b_nan | (a_inf & b_zero) | (b_inf & a_zero);
  assign inf_c  = a_inf | b_inf;
  assign zero_c = a_zero | b_zero;
  assign sgn    = a.sign ^ b.sign;

  assign ma = {1'b1, a.frac};
  assign mb = {1'b1, b.frac};

  fmul_csa #(.MW(MANT_W)) u_csa (
    .ma_i (ma),
    .mb_i (mb),
    .sum_o(s_vec),
    .cry_o(c_vec)
  );

  assign {lo_cy, lo_sum} = {1'b0, s_vec[LO_W-1:0]} + {1'b0, c_vec[LO_W-1:0]};

  fmul_flag_add #(.W(UP_W)) u_add (
    .a_i   (s_vec[PROD_W-1:LO_W]),
    .b_i   (c_vec[PROD_W-1:LO_W]),
    .sum0_o(cand0),
    .sum1_o(cand1),
    .sum2_o(cand2)
  );

  // the true upper field is sum plus the low carry
  assign msb = lo_cy ? cand1[UP_W-1] : cand0[UP_W-1];

  fmul_rnd_sel u_sel (
    .lo_cy_i (lo_cy),
    .lo_top_i(lo_sum[LO_W-1]),
    .sticky_i(|lo_sum[LO_W-2:0]),
    .msb_i   (msb),
    .up_lo_i (lo_cy ? cand1[1:0] : cand0[1:0]),
    .sel_o   (sel)
  );

  always_comb begin
    unique case (sel)
      2'd1:    res = cand1;
      2'd2:    res = cand2;
      default: res = cand0;
    endcase
  end

  assign ovf  = ~msb & res[UP_W-1];
  assign frac = msb ? res[UP_W-2:1] : res[FRAC_W-1:0];
  assign e_calc = ECALC_W'(a.expo) + ECALC_W'(b.expo) - ECALC_W'(BIAS)
                + ECALC_W'(msb) + ECALC_W'(ovf);

  always_comb begin
    if (nan_c)                                  prod_d = QNAN;
    else if (inf_c)                             prod_d = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (zero_c)                            prod_d = {sgn, {(WORD_W-1){1'b0}}};
    else if (e_calc >= ECALC_W'(EXP_MAX))       prod_d = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (e_calc <= 0)                       prod_d = {sgn, {(WORD_W-1){1'b0}}};
    else                                        prod_d = {sgn, e_calc[EXP_W-1:0], frac};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= prod_d;
  end

  // checks
  logic [PROD_W-1:0] chk_csa, chk_mul;
  assign chk_csa = s_vec + c_vec;
  assign chk_mul = PROD_W'(ma) * PROD_W'(mb);

  assert_csa_exact_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_csa == chk_mul);

  assert_sel_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel != 2'd3);

  assert_nan_canon_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nan_c |=> prod_o == QNAN);

  assert_sign_xor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nan_c |=> prod_o[WORD_W-1] == $past(op_a_i[WORD_W-1] ^ op_b_i[WORD_W-1]));

  assert_zero_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_c && !nan_c && !inf_c) |=> prod_o[WORD_W-2:0] == '0);

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nan_c && !inf_c && !zero_c && e_calc >= ECALC_W'(EXP_MAX))
      |=> prod_o[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  assert_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nan_c && !inf_c && !zero_c && e_calc <= 0) |=> prod_o[WORD_W-2:0] == '0);
endmodule

// File: tb/sim_fmul_rne.sv
`timescale 1ns/1ps
module sim_fmul_rne;
  localparam real HALF = 2.5;
  localparam int  NVEC = 18;
  localparam int  NRND = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] prod;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  fmul_rne u0 (
    .clk_i (clk),
    .rst_ni(rst_n),
    .op_a_i(op_a),
    .op_b_i(op_b),
    .prod_o(prod)
  );

  // {a, b, expected, requirement number}
  localparam logic [103:0] VEC [NVEC] = '{
    {32'h3F800000, 32'h3F800000, 32'h3F800000, 8'd2},  // R2 1*1
    {32'h40000000, 32'h40400000, 32'h40C00000, 8'd2},  // R2 2*3
    {32'h3FC00000, 32'h3F800001, 32'h3FC00002, 8'd2},  // R2 tie, odd -> up
    {32'h3FC00000, 32'h3F800003, 32'h3FC00004, 8'd2},  // R2 tie, even kept
    {32'h3FC00000, 32'h3FC00000, 32'h40100000, 8'd3},  // R3 product >= 2
    {32'h3FC00000, 32'h3FC00001, 32'h40100001, 8'd3},  // R3 round at shifted LSB
    {32'h3FFFFFFF, 32'h3F800001, 32'h40000000, 8'd3},  // R3 round carry to 2.0
    {32'h7F000000, 32'h40000000, 32'h7F800000, 8'd4},  // R4 overflow
    {32'hFF000000, 32'h40000000, 32'hFF800000, 8'd4},  // R4 negative overflow
    {32'h00800000, 32'h3F000000, 32'h00000000, 8'd5},  // R5 underflow flush
    {32'h80800000, 32'h3F000000, 32'h80000000, 8'd5},  // R5 signed flush
    {32'h00000001, 32'h7F000000, 32'h00000000, 8'd6},  // R6 denormal in
    {32'h80000000, 32'h40A00000, 32'h80000000, 8'd6},  // R6 signed zero
    {32'h7FC12345, 32'h3F800000, 32'h7FC00000, 8'd7},  // R7 NaN in
    {32'h7F800000, 32'h80000000, 32'h7FC00000, 8'd7},  // R7 inf * zero
    {32'h7F800000, 32'h40000000, 32'h7F800000, 8'd8},  // R8 inf * 2
    {32'hFF800000, 32'h40000000, 32'hFF800000, 8'd8},  // R8 -inf * 2
    {32'hC0000000, 32'hC0400000, 32'h40C00000, 8'd9}   // R9 neg * neg
  };

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic sa, sb, s, g, st;
    int ea, eb, e;
    logic [22:0] fa, fb;
    logic [47:0] p;
    logic [24:0] m;
    sa = a[31]; ea = int'(a[30:23]); fa = a[22:0];
    sb = b[31]; eb = int'(b[30:23]); fb = b[22:0];
    s = sa ^ sb;
    if ((ea == 255 && fa != 0) || (eb == 255 && fb != 0) ||
        (ea == 255 && eb == 0) || (eb == 255 && ea == 0)) return 32'h7FC00000;
    if (ea == 255 || eb == 255) return {s, 8'hFF, 23'd0};
    if (ea == 0 || eb == 0) return {s, 31'd0};
    p = {24'd0, 1'b1, fa} * {24'd0, 1'b1, fb};
    e = ea + eb - 127;
    if (p[47]) begin
      m = {1'b0, p[47:24]}; g = p[23]; st = |p[22:0]; e = e + 1;
    end else begin
      m = {1'b0, p[46:23]}; g = p[22]; st = |p[21:0];
    end
    if (g && (st || m[0])) m = m + 25'd1;
    if (m[24]) begin m = m >> 1; e = e + 1; end
    if (e >= 255) return {s, 8'hFF, 23'd0};
    if (e <= 0) return {s, 31'd0};
    return {s, 8'(e), m[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, output logic [31:0] got);
    @(negedge clk);
    op_a = a; op_b = b;
    @(negedge clk);
    got = prod;
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] got;
    // R1 reset state, with live operands
    op_a = 32'h3F800000; op_b = 32'h40000000;
    repeat (3) @(negedge clk);
    check("R1 reset value", prod, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][103:72], VEC[i][71:40], got);
      check($sformatf("R%0d vector %0d", VEC[i][7:0], i), got, VEC[i][39:8]);
    end

    // R1 latency: output changes only at the edge
    @(negedge clk);
    op_a = 32'h40400000; op_b = 32'h40400000;
    #1 check("R1 holds before edge", prod, 32'h40C00000);
    @(negedge clk);
    check("R1 one-cycle latency", prod, 32'h41100000);

    // R10 / R2 random: unconstrained and mid-range exponents
    for (int i = 0; i < NRND; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 3 != 0) begin
        a[30:23] = 8'(70 + ($urandom % 115));
        b[30:23] = 8'(70 + ($urandom % 115));
      end
      apply(a, b, got);
      check($sformatf("R10 R2 random %h*%h", a, b), got, ref_mul(a, b));
    end

    // R5 boundary: result exactly at min normal and just below
    apply(32'h00800000, 32'h3F800000, got);
    check("R5 min normal kept", got, 32'h00800000);
    apply(32'h00FFFFFF, 32'h3F000000, got);
    check("R5 below min normal", got, ref_mul(32'h00FFFFFF, 32'h3F000000));

    // R1 asynchronous reset mid-run
    apply(32'h3F800000, 32'h3F800000, got);
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", prod, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    wrap_up();
  end

  initial begin
    #(HALF * 2.0 * 200000.0);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end
endmodule